// File: doc/BRIEF.md
# Multi-Channel Edge Timestamp Unit

This block records when transitions happen on up to four asynchronous input lines. A free-running timebase counter advances once per prescaled tick while the unit is switched on. When a channel sees a transition of the kind selected for it, the current timebase value is copied into that channel's stamp register and the channel's pending flag is raised. Software reads the stamps and works out intervals between events, such as pulse widths and periods, from their differences.

A single flat register port provides access. It takes a one-cycle write strobe with a byte address and write data, and it returns read data combinationally from the address. The port covers the per-channel edge selectors, the stamp registers, a control word holding the global enable and the prescaler, an interrupt-enable mask, the pending flags and a write-one-to-clear acknowledge word. One interrupt line is raised while any enabled channel has a pending flag.

Top module: `edge_stamp_unit`

## Requirements
- R1: After reset every stamp, edge selector, pending flag, interrupt enable and control field reads as zero, and `irq` is low.
- R2: Each channel's 2-bit selector at byte offset 0x30 + 4·ch picks the trigger: 0 means no trigger, 1 means low-to-high, 2 means high-to-low and 3 means either direction. A transition that is not selected changes neither the stamp nor the flag.
- R3: On a selected transition, the channel's stamp register at offset 0x10 + 4·ch takes the timebase value. Two captures taken D clock cycles apart with prescaler 0 differ by exactly D.
- R4: The prescaler field is control bits [8:4] at offset 0x50. With value P, the timebase advances once every P+1 clock cycles, so captures 4·(P+1)·k cycles apart differ by 4·k.
- R5: The global enable is control bit 10. While it is clear, no transition is captured, no flag is raised and the timebase holds its value.
- R6: The pending flag of channel ch is bit ch+1 of the word at 0x58. Bit 0 and bits above the last channel always read zero.
- R7: Writing to offset 0x5C clears each pending flag whose bit is 1 in the written data and leaves flags whose bit is 0 unchanged. If a capture and a clear of the same flag fall in the same cycle, the flag stays set.
- R8: `irq` is high exactly when some channel has both its pending flag and its enable set. The enable of channel ch is bit ch+1 of the word at 0x54.
- R9: Stamp and flag registers cannot be changed through a write to their own offsets. Selector readback holds only the two written low bits.
- R10: A flag is set on the third rising clock edge after the input changes: two synchronizer stages, then one capture register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sig_in | input | 4 | Asynchronous inputs to be timestamped |
| irq | output | 1 | Interrupt: OR over channels of pending AND enable |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the same clock cycle as a new capture on the same channel. A capture becomes visible three edges after the input change, so the bench changes the input on a falling edge and raises the acknowledge strobe exactly two falling edges later, which makes both act on the same rising edge. Timebase behaviour is checked only through differences between stamps, so the check does not depend on the prescaler phase at the moment of the first capture.

// File: rtl/esu_pkg.sv
package esu_pkg;
   typedef enum logic [1:0] {
      TRIG_OFF  = 2'd0,
      TRIG_RISE = 2'd1,
      TRIG_FALL = 2'd2,
      TRIG_ANY  = 2'd3
   } trig_e;

   // word indexes (byte address >> 2)
   localparam int unsigned WI_STAMP_BASE = 4;   // 0x10
   localparam int unsigned WI_TRIG_BASE  = 12;  // 0x30
   localparam int unsigned WI_CTRL       = 20;  // 0x50
   localparam int unsigned WI_IEN        = 21;  // 0x54
   localparam int unsigned WI_PEND       = 22;  // 0x58
   localparam int unsigned WI_ACK        = 23;  // 0x5C
   localparam int unsigned CTRL_RUN_BIT  = 10;
   localparam int unsigned CTRL_PS_LSB   = 4;
endpackage

// File: rtl/esu_timebase.sv
module esu_timebase #(
   parameter int CNT_W = 32,
   parameter int PS_W  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PS_W-1:0]  ps,
   output logic             tick,
   output logic [CNT_W-1:0] count
);
   logic [PS_W-1:0] div_q;

   assign tick = run && (div_q >= ps);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         count <= '0;
      end else if (!run) begin
         div_q <= '0;
      end else if (tick) begin
         div_q <= '0;
         count <= count + CNT_W'(1);
      end else begin
         div_q <= div_q + PS_W'(1);
      end
   end
endmodule

// File: rtl/esu_chan.sv
module esu_chan #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       din,
   input  logic       run,
   input  logic [1:0] trig,
   output logic       hit
);
   import esu_pkg::*;

   localparam int SH_W = SYNC_STAGES + 1;

   logic [SH_W-1:0] sh_q;
   logic            now_v, old_v, rise, fall;

   generate
      if (SYNC_STAGES < 2) begin : g_bad
         $error("esu_chan: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SH_W-2:0], din};
   end

   assign now_v = sh_q[SYNC_STAGES-1];
   assign old_v = sh_q[SYNC_STAGES];
   assign rise  = now_v & ~old_v;
   assign fall  = ~now_v & old_v;

   always_comb begin
      unique case (trig_e'(trig))
         TRIG_RISE: hit = run & rise;
         TRIG_FALL: hit = run & fall;
         TRIG_ANY:  hit = run & (rise | fall);
         default:   hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit #(
   parameter int NUM_CH      = 4,
   parameter int CNT_W       = 32,
   parameter int PS_W        = 5,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] sig_in,
   output logic              irq
);
   import esu_pkg::*;

   localparam int WORD_W = ADDR_W - 2;

   generate
      if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
         $error("edge_stamp_unit: NUM_CH must be 1..4");
      end
      if (CNT_W > DATA_W || PS_W > 5 || DATA_W < 11 || ADDR_W < 7) begin : g_bad_w
         $error("edge_stamp_unit: width parameters out of range");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   logic              run_q;
   logic [PS_W-1:0]   ps_q;
   logic [NUM_CH-1:0] ien_q, pend_q, cap_vec, ack_bits;
   logic [1:0]        trig_q  [NUM_CH];
   logic [CNT_W-1:0]  stamp_q [NUM_CH];
   logic [CNT_W-1:0]  count_w;
   logic              tick_w, ack_wr;

   assign word     = bus_addr[ADDR_W-1:2];
   assign ack_wr   = bus_wr && (int'(word) == WI_ACK);
   assign ack_bits = ack_wr ? bus_wdata[NUM_CH:1] : '0;

   wire unused_bus = ^{bus_addr[1:0], bus_wdata};

   esu_timebase #(.CNT_W(CNT_W), .PS_W(PS_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .run(run_q), .ps(ps_q),
      .tick(tick_w), .count(count_w)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
         esu_chan #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
            .clk(clk), .rst_n(rst_n), .din(sig_in[gi]), .run(run_q),
            .trig(trig_q[gi]), .hit(cap_vec[gi])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stamp_q[gi] <= '0;
               trig_q[gi]  <= '0;
            end else begin
               if (cap_vec[gi]) stamp_q[gi] <= count_w;
               if (bus_wr && (int'(word) == WI_TRIG_BASE + gi))
                  trig_q[gi] <= bus_wdata[1:0];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         ps_q   <= '0;
         ien_q  <= '0;
         pend_q <= '0;
      end else begin
         if (bus_wr && int'(word) == WI_CTRL) begin
            run_q <= bus_wdata[CTRL_RUN_BIT];
            ps_q  <= bus_wdata[CTRL_PS_LSB +: PS_W];
         end
         if (bus_wr && int'(word) == WI_IEN) ien_q <= bus_wdata[NUM_CH:1];
         // capture wins over a simultaneous acknowledge
         pend_q <= (pend_q & ~ack_bits) | cap_vec;
      end
   end

   assign irq = |(pend_q & ien_q);

   always_comb begin
      bus_rdata = '0;
      if (int'(word) >= WI_STAMP_BASE && int'(word) < WI_STAMP_BASE + NUM_CH)
         bus_rdata[CNT_W-1:0] = stamp_q[int'(word) - WI_STAMP_BASE];
      else if (int'(word) >= WI_TRIG_BASE && int'(word) < WI_TRIG_BASE + NUM_CH)
         bus_rdata[1:0] = trig_q[int'(word) - WI_TRIG_BASE];
      else if (int'(word) == WI_CTRL) begin
         bus_rdata[CTRL_RUN_BIT]         = run_q;
         bus_rdata[CTRL_PS_LSB +: PS_W]  = ps_q;
      end
      else if (int'(word) == WI_IEN)  bus_rdata[NUM_CH:1] = ien_q;
      else if (int'(word) == WI_PEND) bus_rdata[NUM_CH:1] = pend_q;
   end
endmodule

// File: rtl/esu_checker.sv
module esu_checker #(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic              tick,
   input logic [CNT_W-1:0]  count,
   input logic [NUM_CH-1:0] cap_vec,
   input logic [NUM_CH-1:0] pend,
   input logic [NUM_CH-1:0] ien,
   input logic [NUM_CH-1:0] ack_bits,
   input logic              irq
);
   AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> count == $past(count) + CNT_W'(1)); // R4
   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(count)); // R5
   AST_NO_CAPTURE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> cap_vec == '0); // R5
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cap_vec != '0 |=> (pend & $past(cap_vec)) == $past(cap_vec)); // R7
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_bits != '0 |=> (pend & $past(ack_bits) & ~$past(cap_vec)) == '0); // R7
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & ien) == '0 |-> !irq); // R8
endmodule

bind edge_stamp_unit esu_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick_w), .count(count_w),
   .cap_vec(cap_vec), .pend(pend_q), .ien(ien_q), .ack_bits(ack_bits),
   .irq(irq)
);

// File: tb/edge_stamp_unit_bench.sv
module edge_stamp_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  sig_in = '0;
   logic        irq;
   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   edge_stamp_unit u_edge_stamp_unit (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sig_in(sig_in), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      for (int c = 0; c < 4; c++) begin
         rd(8'h10 + 8'(4*c), d); chk("R1 stamp", d, 0);
         rd(8'h30 + 8'(4*c), d); chk("R1 trig", d, 0);
      end
      rd(8'h50, d); chk("R1 ctrl", d, 0);
      rd(8'h54, d); chk("R1 ien", d, 0);
      rd(8'h58, d); chk("R1 pend", d, 0);
      chk("R1 irq", {31'b0, irq}, 0);
   endtask

   task automatic t_latency;
      logic [31:0] d;
      wr(8'h50, 32'h400);
      wr(8'h30, 1);
      wr(8'h5C, 32'h1FF);
      @(negedge clk); sig_in[0] = 1'b1;
      idle(2); rd(8'h58, d); chk("R10 not yet", d & 32'h2, 0);
      idle(1); rd(8'h58, d); chk("R10 third edge", d & 32'h2, 32'h2);
      @(negedge clk); sig_in[0] = 1'b0;
      idle(4); wr(8'h30, 0); wr(8'h5C, 32'h1FF);
   endtask

   task automatic t_spacing(input int ps, input int gap, input int exp, input string req);
      logic [31:0] a, b;
      wr(8'h50, 32'h400 | (ps << 4));
      wr(8'h30, 1);
      @(negedge clk); sig_in[0] = 1'b1;
      idle(5); rd(8'h10, a);
      idle(gap/2 - 5); sig_in[0] = 1'b0;
      idle(gap - gap/2); sig_in[0] = 1'b1;
      idle(5); rd(8'h10, b);
      chk(req, b - a, exp);
      @(negedge clk); sig_in[0] = 1'b0;
      idle(4); wr(8'h30, 0); wr(8'h5C, 32'h1FF);
   endtask

   task automatic t_modes;
      logic [31:0] d;
      wr(8'h50, 32'h400);
      wr(8'h34, 2); wr(8'h38, 3); wr(8'h3C, 0);
      wr(8'h5C, 32'h1FF);
      @(negedge clk); sig_in[3:1] = 3'b111;
      idle(5); rd(8'h58, d); chk("R2 rise: only both-mode ch2", d, 32'h8);
      rd(8'h1C, d); chk("R2 disabled ch3 stamp", d, 0);
      wr(8'h5C, 32'h1FF);
      @(negedge clk); sig_in[3:1] = 3'b000;
      idle(5); rd(8'h58, d); chk("R2 fall: ch1 and ch2", d, 32'hC);
      rd(8'h14, d); chk("R2 falling stamp nonzero", {31'b0, d != 0}, 1);
      wr(8'h34, 0); wr(8'h38, 0); wr(8'h5C, 32'h1FF);
   endtask

   task automatic t_disable;
      logic [31:0] s0, d;
      wr(8'h50, 32'h0);
      wr(8'h30, 3);
      rd(8'h10, s0);
      @(negedge clk); sig_in[0] = 1'b1;
      idle(5); rd(8'h58, d); chk("R5 no flag while off", d, 0);
      rd(8'h10, d); chk("R5 stamp unchanged while off", d, s0);
      @(negedge clk); sig_in[0] = 1'b0;
      idle(4); wr(8'h30, 0);
   endtask

   task automatic t_ack_irq;
      logic [31:0] d;
      wr(8'h50, 32'h400);
      wr(8'h30, 1); wr(8'h34, 1);
      @(negedge clk); sig_in[1:0] = 2'b11;
      idle(5); rd(8'h58, d); chk("R6 flags at bits 2:1", d, 32'h6);
      chk("R8 irq low with no enable", {31'b0, irq}, 0);
      wr(8'h54, 32'h2);
      #1 chk("R8 irq with ch0 enabled", {31'b0, irq}, 1);
      wr(8'h5C, 32'h4);
      rd(8'h58, d); chk("R7 zero bits keep flags", d, 32'h2);
      wr(8'h54, 32'h4);
      #1 chk("R8 irq low, enabled flag cleared", {31'b0, irq}, 0);
      wr(8'h54, 32'h2);
      // R7 set wins: input change at negedge, ack strobe two negedges later
      @(negedge clk); sig_in[0] = 1'b0;
      idle(4);
      wr(8'h5C, 32'h1FF);
      @(negedge clk); sig_in[0] = 1'b1;
      @(negedge clk);
      @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h5C; bus_wdata = 32'h1FF;
      @(negedge clk); bus_wr = 1'b0;
      rd(8'h58, d); chk("R7 capture beats acknowledge", d, 32'h2);
      wr(8'h5C, 32'h2);
      rd(8'h58, d); chk("R7 acknowledge clears", d, 0);
      sig_in = '0; idle(4);
      wr(8'h30, 0); wr(8'h34, 0); wr(8'h54, 0);
   endtask

   task automatic t_map;
      logic [31:0] s, d;
      rd(8'h10, s);
      wr(8'h10, 32'hDEAD_BEEF);
      rd(8'h10, d); chk("R9 stamp read-only", d, s);
      wr(8'h58, 32'h1E);
      rd(8'h58, d); chk("R9 flags not writable", d, 0);
      wr(8'h38, 32'hFFFF_FFFF);
      rd(8'h38, d); chk("R9 selector two bits", d, 3);
      wr(8'h38, 0);
      wr(8'h50, 32'h5F0);
      rd(8'h50, d); chk("R4 ctrl readback", d, 32'h5F0);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      t_reset;
      rst_n = 1'b1;
      idle(2);
      t_latency;
      t_spacing(0, 30, 30, "R3 stamp difference");
      t_spacing(3, 40, 10, "R4 prescaled difference");
      t_spacing(1, 24, 12, "R4 prescale 1");
      t_modes;
      t_disable;
      t_ack_irq;
      t_map;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule